// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Store

This block models a three-wire serial EEPROM organised as 16-bit words. A host selects the part with a chip-select line, toggles a shift clock, and presents one command bit per clock on a serial data input. The block answers on a serial data output. Each command is a start bit of 1, a two-bit opcode and an address. The address is 6 bits wide (64 words) or 8 bits wide (256 words), chosen by a parameter. The supported commands are read, write, erase, write-enable and write-disable.

All pins are sampled by the block's own clock. A shift-clock rising edge is detected internally. The host changes the data input while the shift clock is low and samples the data output after the shift clock has risen. A read puts a zero bit on the output at the last address bit, then shifts out the addressed word. Because the output rests high outside read data and busy reporting, a host can learn the address width by clocking an overlong read. Write and erase run as a self-timed programming cycle, which starts when chip-select falls. While chip-select is held during that cycle, the output reports busy (low) and then ready (high).

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word reads 0xFFFF, the write-enable latch is clear, and the data output is high while chip-select is low.
- R2: A read (start 1, opcode bits 1,0, then the address MSB first) drives a 0 on the data output after the shift-clock edge of the last address bit. The 16 following edges then present the addressed word, MSB first.
- R3: Write and erase commands while the write-enable latch is clear change no word and start no programming cycle.
- R4: Write-enable is start 1, opcode 0,0 and an address whose two top bits are 1,1; it sets the latch. A write (start 1, opcode 0,1, address, 16 data bits MSB first) then stores the data in the addressed word.
- R5: An erase (start 1, opcode 1,1, address) with the latch set leaves the addressed word at 0xFFFF.
- R6: Write-disable is start 1, opcode 0,0 and an address whose two top bits are 0,0; it clears the latch, so later writes are ignored.
- R7: Programming starts when chip-select falls after a complete, enabled write or erase, and lasts PROG_CYCLES clock cycles. With chip-select high during that time, the data output is low, and it turns high once programming is finished.
- R8: Dropping chip-select before a command is complete aborts it; a write cut short stores nothing.
- R9: The data output is high during the idle, opcode, address and write-data phases. An overlong read probe with a 6-bit address therefore shows bit 16 of the captured stream as 1 on an 8-bit part and as 0 on a 6-bit part.
- R10: Start bits received while programming is busy are ignored; no command begins.
- R11: Zero bits ahead of the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high; low ends any command |
| sk_i | input | 1 | Serial shift clock from the host |
| di_i | input | 1 | Serial command, address and data input |
| do_o | output | 1 | Serial data output and ready/busy indicator |

## Verification
The hardest state to reach is a command that arrives while a programming cycle is running. The window is only PROG_CYCLES clocks, and the host's own bit timing uses up part of it. The bench raises chip-select again right after an enabled write and clocks a read start sequence inside that window, checking that the output stays low. It then keeps chip-select high past the ready edge and clocks a full address length of zeros. Any dummy zero on the output would show that the discarded start bit had opened a read.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int DATA_W = 16;

  localparam logic [1:0] OPC_MISC  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DIN,
    ST_DOUT,
    ST_DONE
  } mw_state_e;
endpackage

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         raddr_i,
  output logic [mw_pkg::DATA_W-1:0] rdata_o,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [mw_pkg::DATA_W-1:0] wdata_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [mw_pkg::DATA_W-1:0] mem_q [DEPTH];

  // reset fills the array with the erased value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              prog_go_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              wen_o,
  output logic              idle_o,
  output logic              do_o
);
  localparam int CNT_W = $clog2(((ADDR_W > DATA_W) ? ADDR_W : DATA_W) + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mw_state_e         st_q;
  logic              sk_q, cs_q;
  logic [1:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_q;
  logic              wen_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;

  logic              sk_rise, cs_fall;
  logic [ADDR_W-1:0] addr_full;
  logic [1:0]        addr_top;

  assign sk_rise   = cs_i & sk_i & ~sk_q;
  assign cs_fall   = cs_q & ~cs_i;
  assign addr_full = {addr_q[ADDR_W-2:0], di_i};
  assign addr_top  = addr_full[ADDR_W-1 -: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sk_q        <= 1'b0;
      cs_q        <= 1'b0;
      opc_q       <= '0;
      addr_q      <= '0;
      sh_q        <= '0;
      cnt_q       <= '0;
      do_q        <= 1'b1;
      wen_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
      if (cs_fall) pend_q <= 1'b0;
      if (!cs_i) begin
        st_q  <= ST_IDLE;
        do_q  <= 1'b1;
        cnt_q <= '0;
      end else if (sk_rise) begin
        unique case (st_q)
          ST_IDLE: begin
            // leading zeros and starts during programming are dropped
            if (di_i && !busy_i) begin
              st_q  <= ST_OPC;
              cnt_q <= '0;
            end
          end
          ST_OPC: begin
            opc_q <= {opc_q[0], di_i};
            if (cnt_q == CNT_W'(1)) begin
              st_q  <= ST_ADDR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_q <= addr_full;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == ADDR_LAST) begin
              cnt_q <= '0;
              unique case (opc_q)
                OPC_READ: begin
                  sh_q <= rdata_i;
                  do_q <= 1'b0;               // dummy bit
                  st_q <= ST_DOUT;
                end
                OPC_WRITE: st_q <= ST_DIN;
                OPC_ERASE: begin
                  pend_q      <= wen_q;
                  pend_addr_q <= addr_full;
                  pend_data_q <= '1;
                  st_q        <= ST_DONE;
                end
                default: begin
                  if (addr_top == 2'b11)      wen_q <= 1'b1;
                  else if (addr_top == 2'b00) wen_q <= 1'b0;
                  st_q <= ST_DONE;
                end
              endcase
            end
          end
          ST_DIN: begin
            sh_q  <= {sh_q[DATA_W-2:0], di_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == DATA_LAST) begin
              pend_q      <= wen_q;
              pend_addr_q <= addr_q;
              pend_data_q <= {sh_q[DATA_W-2:0], di_i};
              st_q        <= ST_DONE;
            end
          end
          ST_DOUT: begin
            do_q  <= sh_q[DATA_W-1];
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == DATA_LAST) st_q <= ST_DONE;
          end
          default: do_q <= 1'b1;
        endcase
      end
    end
  end

  assign rd_addr_o   = addr_full;
  assign prog_go_o   = cs_fall & pend_q;
  assign prog_addr_o = pend_addr_q;
  assign prog_data_o = pend_data_q;
  assign wen_o       = wen_q;
  assign idle_o      = (st_q == ST_IDLE);
  assign do_o        = do_q;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  localparam int DW = mw_pkg::DATA_W;

  logic [ADDR_W-1:0] rd_addr, prog_addr;
  logic [DW-1:0]     rdata, prog_data;
  logic              prog_go, busy, wen, dec_idle, dec_do;

  mw_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .sk_i        (sk_i),
    .di_i        (di_i),
    .busy_i      (busy),
    .rdata_i     (rdata),
    .rd_addr_o   (rd_addr),
    .prog_go_o   (prog_go),
    .prog_addr_o (prog_addr),
    .prog_data_o (prog_data),
    .wen_o       (wen),
    .idle_o      (dec_idle),
    .do_o        (dec_do)
  );

  mw_word_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (rd_addr),
    .rdata_o (rdata),
    .we_i    (prog_go),
    .waddr_i (prog_addr),
    .wdata_i (prog_data)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_go),
    .busy_o  (busy)
  );

  // released line reads high; busy pulls low while selected
  assign do_o = !cs_i ? 1'b1 : (busy ? 1'b0 : dec_do);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int PROG_CYCLES = 40
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic busy,
  input logic prog_go,
  input logic wen,
  input logic dec_idle
);
  localparam int RW = $clog2(PROG_CYCLES + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(PROG_CYCLES);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (busy) run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    else           run_q <= '0;
  end

  p_prog_needs_wen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go |-> wen);

  p_go_then_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go |=> busy);

  p_busy_bounded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (run_q < RUN_MAX));

  p_cs_low_aborts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> dec_idle);

  p_no_cmd_while_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> dec_idle);
endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_i     (cs_i),
  .busy     (busy),
  .prog_go  (prog_go),
  .wen      (wen),
  .dec_idle (dec_idle)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 8;
  localparam int PROG_CYCLES = 40;
  localparam int DEPTH       = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;

  logic [15:0] model [DEPTH];
  bit          model_wen = 1'b0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] mon_word;
  logic        mon_dummy;
  int          mon_seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(dout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(mon_seq);
      if (exp_q.size() == 0) chk(1'b0, "scoreboard-underflow", mon_word, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(mon_dummy === 1'b0, {t, " dummy"}, {31'b0, mon_dummy}, 0);
        chk(mon_word === e, t, mon_word, e);
      end
    end
  end

  task automatic bit_io(input logic b, output logic o);
    @(negedge clk); di = b; sk = 1'b0;
    @(negedge clk); @(negedge clk); sk = 1'b1;
    @(negedge clk); @(negedge clk); o = dout;
  endtask

  task automatic shift(input logic [31:0] v, input int n, output logic [31:0] cap);
    logic o;
    cap = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_io(v[i], o);
      cap = {cap[30:0], o};
    end
  endtask

  task automatic cs_high();
    @(negedge clk); cs = 1'b1; sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk); cs = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int a, input int lead, input string tag);
    logic [31:0] cap;
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
    cs_high();
    if (lead > 0) shift('0, lead, cap);
    shift((32'b110 << ADDR_W) | 32'(a), 3 + ADDR_W, cap);
    mon_dummy = cap[0];
    shift('0, 16, cap);
    mon_word = cap[15:0];
    cs_low();
    mon_seq++;
  endtask

  task automatic wr_cmd(input int a, input logic [15:0] d);
    logic [31:0] cap;
    cs_high();
    shift((32'b101 << ADDR_W) | 32'(a), 3 + ADDR_W, cap);
    chk(cap[ADDR_W+2:0] == '1, "R9 do high in cmd/addr", cap, '1);
    shift({16'b0, d}, 16, cap);
    chk(cap[15:0] == 16'hFFFF, "R9 do high in write data", cap, 32'hFFFF);
    cs_low();
    if (model_wen) model[a] = d;
  endtask

  task automatic er_cmd(input int a);
    logic [31:0] cap;
    cs_high();
    shift((32'b111 << ADDR_W) | 32'(a), 3 + ADDR_W, cap);
    cs_low();
    if (model_wen) model[a] = 16'hFFFF;
  endtask

  task automatic misc_cmd(input logic [1:0] top);
    logic [31:0] cap;
    cs_high();
    shift((32'b100 << ADDR_W) | (32'(top) << (ADDR_W - 2)), 3 + ADDR_W, cap);
    cs_low();
    if (top == 2'b11) model_wen = 1'b1;
    if (top == 2'b00) model_wen = 1'b0;
  endtask

  // samples taken until DO is high; 1 means ready at once
  task automatic wait_ready(output int n);
    @(negedge clk); cs = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (dout !== 1'b1 && n < 1000);
    cs_low();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] cap;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chk(dout === 1'b1, "R1 do high after reset", {31'b0, dout}, 1);
    rd(5, 0, "R1 R2 erased word after reset");
    rd(DEPTH - 1, 0, "R1 R2 last word after reset");

    // write without enable
    wr_cmd(5, 16'h1234);
    wait_ready(n);
    chk(n == 1, "R3 no programming when latch clear", n, 1);
    rd(5, 0, "R3 word unchanged");

    // enable and write
    misc_cmd(2'b11);
    wr_cmd(5, 16'hA5C3);
    wait_ready(n);
    chk(n >= 30 && n <= 42, "R7 busy low then ready after write", n, PROG_CYCLES);
    rd(5, 0, "R4 R2 written word");
    wr_cmd(DEPTH - 1, 16'h8001);
    wait_ready(n);
    wr_cmd(0, 16'h0001);
    wait_ready(n);
    rd(DEPTH - 1, 0, "R4 top address");
    rd(0, 0, "R4 address zero");
    rd(5, 0, "R4 neighbour unaffected");

    // erase
    er_cmd(5);
    wait_ready(n);
    chk(n >= 30 && n <= 42, "R5 R7 erase busy window", n, PROG_CYCLES);
    rd(5, 0, "R5 erased word");

    // aborted write
    cs_high();
    shift((32'b101 << ADDR_W) | 32'd7, 3 + ADDR_W, cap);
    shift(32'h00AA, 8, cap);
    cs_low();
    wait_ready(n);
    chk(n == 1, "R8 abort starts no programming", n, 1);
    rd(7, 0, "R8 aborted word unchanged");

    // start bits while busy
    wr_cmd(9, 16'h5555);
    cs_high();
    shift(32'b110, 3, cap);
    chk(cap[2:0] == 3'b000, "R10 do low while busy", cap[2:0], 0);
    n = 0;
    while (dout !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    shift('0, ADDR_W + 1, cap);
    chk(cap[ADDR_W:0] == '1, "R10 start bit during busy ignored", cap[ADDR_W:0], '1);
    cs_low();
    rd(9, 0, "R10 word after busy");

    // leading zeros
    rd(0, 3, "R11 read after leading zeros");

    // disable
    misc_cmd(2'b00);
    wr_cmd(5, 16'h0F0F);
    wait_ready(n);
    chk(n == 1, "R6 write ignored after disable", n, 1);
    er_cmd(0);
    wait_ready(n);
    chk(n == 1, "R6 R3 erase ignored after disable", n, 1);
    rd(5, 0, "R6 word kept");
    rd(0, 0, "R6 R3 word kept after erase");

    // address-width probe: 0,1,1,0 then 22 zeros
    cs_high();
    shift(32'b0110 << 22, 26, cap);
    cs_low();
    chk(cap[25:22] == 4'b1111, "R9 do high idle/opcode", cap[25:22], 4'hF);
    chk(cap[16] == ((ADDR_W == 8) ? 1'b1 : 1'b0), "R9 R11 sizing bit16",
        {31'b0, cap[16]}, (ADDR_W == 8) ? 1 : 0);
    chk(dout === 1'b1, "R9 do high with cs low", {31'b0, dout}, 1);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule